// File: doc/BRIEF.md
# Prioritized interrupt delegation resolver

This block decides, in the same cycle as its inputs change, whether a hart should take an interrupt, which interrupt, and at which privilege it is handled. Its inputs are the pending and enable vectors, two delegation masks (machine to supervisor, supervisor to user), the three global enable bits and the current privilege. Pending bits, interrupt sources and the trap entry itself live elsewhere. The trap sequencer reads the three outputs directly.

The resolver walks the privilege levels from machine downward. Each level keeps the enabled pending bits that it does not delegate, and hands the pending bits it does delegate to the next level down. A level above the current privilege is always enabled. A level below it is always blocked. Only after one level has been chosen does a fixed nine-way priority pick the interrupt. Three parameters set which privilege levels exist: machine only, machine/user, or machine/supervisor/user, with or without user-level interrupts.

Top module: `irq_deleg_resolver`

## Requirements
- R1: When no bit of (pending AND enable) is set, `take` is 0. Whenever `take` is 0, `cause` and `tgt_priv` are both 0.
- R2: The set pending AND enable AND NOT `m_deleg` is handled at machine level (`tgt_priv` = 2'b11) when the machine level is enabled. It is enabled when `cur_priv` is below machine, or when `cur_priv` is machine and `m_gie` is 1.
- R3: Bit positions are: user software 0, supervisor software 1, machine software 3, user timer 4, supervisor timer 5, machine timer 7, user external 8, supervisor external 9, machine external 11. Within the chosen set, priority from highest to lowest is machine external, software, timer, then supervisor external, software, timer, then user external, software, timer. `cause` equals the bit index.
- R4: If machine level reports nothing, pending AND `m_deleg` passes to the supervisor level. There, the bits that are enabled and not in `s_deleg` are handled at supervisor (2'b01) when supervisor is enabled: `cur_priv` is user (2'b00), or `cur_priv` is supervisor and `s_gie` is 1.
- R5: If supervisor reports nothing, pending AND `m_deleg` AND `s_deleg` is handled at user (2'b00), but only when user interrupts are configured, `cur_priv` is user and `u_gie` is 1. This set is not masked by enable. It is considered only while some bit of (pending AND enable) is set.
- R6: An interrupt is never handled at a level below `cur_priv`. With `cur_priv` machine and `m_gie` 0, nothing is taken outside the flat configuration.
- R7: Without supervisor mode, but with user mode and user interrupts, the machine-delegated set goes straight to user under the R5 conditions. `s_deleg` and `s_gie` have no effect.
- R8: Flat configuration (no user mode, or neither supervisor mode nor user interrupts): the delegation masks, the global enables and `cur_priv` are ignored, and the highest-priority enabled pending interrupt is handled at machine level.
- R9: Bits outside the nine positions of R3 never cause `take`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| irq_pend | input | XLEN | Pending interrupt bits |
| irq_en | input | XLEN | Interrupt enable bits |
| m_deleg | input | XLEN | Machine-to-supervisor delegation mask |
| s_deleg | input | XLEN | Supervisor-to-user delegation mask |
| m_gie | input | 1 | Machine global interrupt enable |
| s_gie | input | 1 | Supervisor global interrupt enable |
| u_gie | input | 1 | User global interrupt enable |
| cur_priv | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine |
| take | output | 1 | An interrupt must be taken now |
| cause | output | $clog2(XLEN) | Bit index of the chosen interrupt |
| tgt_priv | output | 2 | Privilege that handles it |

## Verification
The bench builds three instances with XLEN = 16.

- The full machine/supervisor/user configuration with user interrupts reaches every delegation path, the pass-down of pending bits that are not enabled, and the blocking of lower levels.
- A machine/user build with user interrupts and no supervisor shows the machine-delegated set going straight to user, with the supervisor mask ignored.
- A machine/user build without user interrupts falls into the flat configuration, where masks, global enables and privilege must have no effect.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;

  typedef enum logic [1:0] {
    PRV_U = 2'b00,
    PRV_S = 2'b01,
    PRV_M = 2'b11
  } prv_e;

  localparam int NUM_SRC = 9;

  // Bit index of the source with the given rank; rank 0 has the highest priority.
  function automatic int unsigned src_pos(input int unsigned rank);
    case (rank)
      0: return 11;
      1: return 3;
      2: return 7;
      3: return 9;
      4: return 1;
      5: return 5;
      6: return 8;
      7: return 0;
      default: return 4;
    endcase
  endfunction

  // A configuration without real privilege separation handles everything at machine level.
  function automatic bit flat_cfg(input bit has_s, input bit has_u, input bit has_ui);
    return !has_u || (!has_s && !has_ui);
  endfunction

endpackage

// File: rtl/irq_level_split.sv
module irq_level_split #(
  parameter int W = 16
) (
  input  logic [W-1:0] pend,
  input  logic [W-1:0] en,
  input  logic [W-1:0] deleg,
  input  logic         lvl_on,
  output logic [W-1:0] own_set,
  output logic [W-1:0] down_set,
  output logic         own_hit,
  output logic         down_hit
);
  // Kept by this level: pending, enabled, not delegated.
  assign own_set  = pend & en & ~deleg;
  // Handed to the next level down: pending and delegated.
  assign down_set = pend & deleg;
  assign own_hit  = lvl_on && (|own_set);
  assign down_hit = !own_hit && (|down_set);
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int W  = 16,
  parameter int CW = 4
) (
  input  logic [W-1:0]  cand,
  output logic          hit,
  output logic [CW-1:0] code
);
  import irq_res_pkg::*;

  always_comb begin
    hit  = 1'b0;
    code = '0;
    // Walk from lowest to highest priority so the last match wins.
    for (int r = NUM_SRC - 1; r >= 0; r--) begin
      if (cand[src_pos(r)]) begin
        hit  = 1'b1;
        code = CW'(src_pos(r));
      end
    end
  end
endmodule

// File: rtl/irq_deleg_resolver.sv
module irq_deleg_resolver #(
  parameter int XLEN     = 16,
  parameter bit HAS_SUP  = 1'b1,
  parameter bit HAS_USR  = 1'b1,
  parameter bit HAS_UIRQ = 1'b1,
  localparam int CW      = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] irq_pend,
  input  logic [XLEN-1:0] irq_en,
  input  logic [XLEN-1:0] m_deleg,
  input  logic [XLEN-1:0] s_deleg,
  input  logic            m_gie,
  input  logic            s_gie,
  input  logic            u_gie,
  input  logic [1:0]      cur_priv,
  output logic            take,
  output logic [CW-1:0]   cause,
  output logic [1:0]      tgt_priv
);
  import irq_res_pkg::*;

  localparam bit FLAT = flat_cfg(HAS_SUP, HAS_USR, HAS_UIRQ);
  localparam logic [XLEN-1:0] STD_MASK = XLEN'(16'h0BBB);

  logic [XLEN-1:0] eff_set;
  logic            eff_any;
  logic            m_on, s_on, u_on;

  assign eff_set = irq_pend & irq_en;
  assign eff_any = |eff_set;

  // Level enables: above current privilege always on, below always off.
  assign m_on = (cur_priv != PRV_M) || m_gie;
  assign s_on = HAS_SUP && ((cur_priv == PRV_U) || ((cur_priv == PRV_S) && s_gie));
  assign u_on = HAS_UIRQ && (cur_priv == PRV_U) && u_gie;

  logic [XLEN-1:0] m_own_set, m_down_set;
  logic            m_own_hit, m_down_hit;

  irq_level_split #(.W(XLEN)) u_mlvl (
    .pend     (irq_pend),
    .en       (irq_en),
    .deleg    (m_deleg),
    .lvl_on   (m_on),
    .own_set  (m_own_set),
    .down_set (m_down_set),
    .own_hit  (m_own_hit),
    .down_hit (m_down_hit)
  );

  logic [XLEN-1:0] s_own_set, s_down_set;
  logic            s_own_hit, s_down_hit;

  generate
    if (HAS_SUP) begin : g_sup
      irq_level_split #(.W(XLEN)) u_slvl (
        .pend     (m_down_set),
        .en       (irq_en),
        .deleg    (s_deleg),
        .lvl_on   (s_on),
        .own_set  (s_own_set),
        .down_set (s_down_set),
        .own_hit  (s_own_hit),
        .down_hit (s_down_hit)
      );
    end else begin : g_nosup
      // Machine-delegated bits go straight to the user level.
      assign s_own_set  = '0;
      assign s_down_set = m_down_set;
      assign s_own_hit  = 1'b0;
      assign s_down_hit = m_down_hit;
    end
  endgenerate

  logic [XLEN-1:0] sel_set;
  logic [1:0]      sel_priv;
  logic            sel_ok;

  always_comb begin
    sel_set  = '0;
    sel_priv = PRV_M;
    sel_ok   = 1'b0;
    if (FLAT) begin
      sel_set = eff_set;
      sel_ok  = eff_any;
    end else if (eff_any && m_own_hit) begin
      sel_set = m_own_set;
      sel_ok  = 1'b1;
    end else if (eff_any && m_down_hit && s_own_hit) begin
      sel_set  = s_own_set;
      sel_priv = PRV_S;
      sel_ok   = 1'b1;
    end else if (eff_any && m_down_hit && s_down_hit && u_on) begin
      sel_set  = s_down_set;
      sel_priv = PRV_U;
      sel_ok   = 1'b1;
    end
  end

  logic          pick_hit;
  logic [CW-1:0] pick_code;

  irq_prio_pick #(.W(XLEN), .CW(CW)) u_pick (
    .cand (sel_set),
    .hit  (pick_hit),
    .code (pick_code)
  );

  assign take     = sel_ok && pick_hit;
  assign cause    = take ? pick_code : '0;
  assign tgt_priv = take ? sel_priv : 2'b00;

  // Checks relating the ports to each other and to the selection stages.
  always_comb begin
    assert_quiet_when_idle_R1: assert (eff_any || !take)
      else $error("take raised with no enabled pending bit");
    assert_idle_outputs_R1: assert (take || (cause == '0 && tgt_priv == 2'b00))
      else $error("outputs not cleared while idle");
    assert_machine_not_delegated_R2: assert (FLAT || !(take && tgt_priv == PRV_M) || !m_deleg[cause])
      else $error("delegated interrupt handled at machine");
    assert_cause_pending_R3: assert (!take || irq_pend[cause])
      else $error("cause not pending");
    assert_super_path_R4: assert (!(take && tgt_priv == PRV_S) || (m_deleg[cause] && !s_deleg[cause]))
      else $error("supervisor target without matching delegation");
    assert_user_path_R5: assert (!(HAS_SUP && take && tgt_priv == PRV_U)
                                 || (m_deleg[cause] && s_deleg[cause] && u_gie && cur_priv == PRV_U))
      else $error("user target without matching delegation or enable");
    assert_no_lower_target_R6: assert (!take || tgt_priv >= cur_priv)
      else $error("target below current privilege");
    assert_masked_machine_R6: assert (FLAT || !(cur_priv == PRV_M && !m_gie) || !take)
      else $error("take while machine disabled at machine privilege");
    assert_nosup_direct_R7: assert (HAS_SUP || FLAT || !(take && tgt_priv == PRV_U)
                                    || (m_deleg[cause] && u_gie))
      else $error("user target without machine delegation");
    assert_flat_machine_R8: assert (!FLAT || !take || tgt_priv == PRV_M)
      else $error("flat configuration targeted non-machine");
    assert_std_cause_R9: assert (!take || STD_MASK[cause])
      else $error("cause outside standard positions");
  end

endmodule

// File: tb/sim_irq_deleg_resolver.sv
`timescale 1ns/1ps
module sim_irq_deleg_resolver;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic [15:0] pend, en, md, sd;
  logic        mg, sg, ug;
  logic [1:0]  pr;

  logic       t0, t1, t2;
  logic [3:0] c0, c1, c2;
  logic [1:0] p0, p1, p2;

  int n_chk = 0;
  int n_bad = 0;

  // Full machine/supervisor/user with user interrupts.
  irq_deleg_resolver #(.XLEN(16), .HAS_SUP(1'b1), .HAS_USR(1'b1), .HAS_UIRQ(1'b1)) u0 (
    .irq_pend(pend), .irq_en(en), .m_deleg(md), .s_deleg(sd),
    .m_gie(mg), .s_gie(sg), .u_gie(ug), .cur_priv(pr),
    .take(t0), .cause(c0), .tgt_priv(p0));

  // Machine/user with user interrupts, no supervisor.
  irq_deleg_resolver #(.XLEN(16), .HAS_SUP(1'b0), .HAS_USR(1'b1), .HAS_UIRQ(1'b1)) u1 (
    .irq_pend(pend), .irq_en(en), .m_deleg(md), .s_deleg(sd),
    .m_gie(mg), .s_gie(sg), .u_gie(ug), .cur_priv(pr),
    .take(t1), .cause(c1), .tgt_priv(p1));

  // Machine/user without user interrupts: flat.
  irq_deleg_resolver #(.XLEN(16), .HAS_SUP(1'b0), .HAS_USR(1'b1), .HAS_UIRQ(1'b0)) u2 (
    .irq_pend(pend), .irq_en(en), .m_deleg(md), .s_deleg(sd),
    .m_gie(mg), .s_gie(sg), .u_gie(ug), .cur_priv(pr),
    .take(t2), .cause(c2), .tgt_priv(p2));

  typedef struct packed {
    logic [15:0] pend, en, md, sd;
    logic        mg, sg, ug;
    logic [1:0]  pr;
    logic        tk;
    logic [3:0]  cs;
    logic [1:0]  tg;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 19;
  // Privilege: 00 user, 01 supervisor, 11 machine.
  localparam vec_t TBL [NV] = '{
    '{16'h0BBB, 16'h0000, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 4'd0,  2'b00, 4'd1}, // R1 nothing enabled
    '{16'h0BBB, 16'hFFFF, 16'h0000, 16'h0000, 1'b1, 1'b0, 1'b0, 2'b11, 1'b1, 4'd11, 2'b11, 4'd3}, // R3 all pending
    '{16'h0088, 16'hFFFF, 16'h0000, 16'h0000, 1'b1, 1'b0, 1'b0, 2'b11, 1'b1, 4'd3,  2'b11, 4'd3}, // R3 sw over timer
    '{16'h0080, 16'hFFFF, 16'h0000, 16'h0000, 1'b1, 1'b0, 1'b0, 2'b11, 1'b1, 4'd7,  2'b11, 4'd3}, // R3 timer
    '{16'h0222, 16'hFFFF, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 2'b01, 1'b1, 4'd9,  2'b11, 4'd2}, // R2 undelegated S irq at M
    '{16'h0022, 16'hFFFF, 16'h0222, 16'h0000, 1'b0, 1'b1, 1'b0, 2'b01, 1'b1, 4'd1,  2'b01, 4'd4}, // R4 at S
    '{16'h0020, 16'hFFFF, 16'h0222, 16'h0000, 1'b1, 1'b0, 1'b0, 2'b01, 1'b0, 4'd0,  2'b00, 4'd4}, // R4 S disabled
    '{16'h0020, 16'hFFFF, 16'h0222, 16'h0000, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 4'd5,  2'b01, 4'd4}, // R4 S on from user
    '{16'h0111, 16'hFFFF, 16'h0111, 16'h0111, 1'b0, 1'b0, 1'b1, 2'b00, 1'b1, 4'd8,  2'b00, 4'd5}, // R5 at U
    '{16'h0111, 16'hFFFF, 16'h0111, 16'h0111, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 4'd0,  2'b00, 4'd5}, // R5 u_gie clear
    '{16'h0111, 16'hFFFF, 16'h0111, 16'h0111, 1'b0, 1'b1, 1'b1, 2'b01, 1'b0, 4'd0,  2'b00, 4'd6}, // R6 U blocked from S
    '{16'h0808, 16'hFFFF, 16'h0008, 16'h0000, 1'b1, 1'b0, 1'b0, 2'b11, 1'b1, 4'd11, 2'b11, 4'd2}, // R2 own M set
    '{16'h0008, 16'hFFFF, 16'h0008, 16'h0000, 1'b1, 1'b1, 1'b0, 2'b11, 1'b0, 4'd0,  2'b00, 4'd6}, // R6 S blocked from M
    '{16'h0011, 16'h0010, 16'h0011, 16'h0011, 1'b0, 1'b0, 1'b1, 2'b00, 1'b1, 4'd0,  2'b00, 4'd5}, // R5 unmasked pass-down
    '{16'h0010, 16'h0001, 16'h0011, 16'h0011, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 4'd0,  2'b00, 4'd1}, // R1 no enabled pending
    '{16'h7000, 16'hFFFF, 16'h0000, 16'h0000, 1'b1, 1'b0, 1'b0, 2'b11, 1'b0, 4'd0,  2'b00, 4'd9}, // R9 nonstandard bits
    '{16'h0300, 16'hFFFF, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 4'd9,  2'b11, 4'd3}, // R3 SEI over UEI
    '{16'h0A00, 16'hFFFF, 16'h0800, 16'h0000, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1, 4'd9,  2'b11, 4'd2}, // R2 M keeps undelegated
    '{16'h0800, 16'hFFFF, 16'h0800, 16'h0000, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 4'd11, 2'b01, 4'd4}  // R4 delegated MEI at S
  };

  task automatic chk(input string rq, input logic tk, input logic [3:0] cs, input logic [1:0] tg,
                     input logic etk, input logic [3:0] ecs, input logic [1:0] etg);
    n_chk++;
    if ({tk, cs, tg} !== {etk, ecs, etg}) begin
      n_bad++;
      $display("FAIL %s: take=%0b cause=%0d tgt=%0b, expected take=%0b cause=%0d tgt=%0b",
               rq, tk, cs, tg, etk, ecs, etg);
    end
  endtask

  task automatic drive(input logic [15:0] a, b, c, d, input logic g0, g1, g2, input logic [1:0] q);
    @(posedge clk);
    pend = a; en = b; md = c; sd = d; mg = g0; sg = g1; ug = g2; pr = q;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    pend = '0; en = '0; md = '0; sd = '0; mg = 1'b0; sg = 1'b0; ug = 1'b0; pr = 2'b11;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Quiet start: no inputs, no interrupt (R1).
    chk("R1 start u0", t0, c0, p0, 1'b0, 4'd0, 2'b00);
    chk("R1 start u2", t2, c2, p2, 1'b0, 4'd0, 2'b00);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].pend, TBL[i].en, TBL[i].md, TBL[i].sd, TBL[i].mg, TBL[i].sg, TBL[i].ug, TBL[i].pr);
      chk($sformatf("R%0d row %0d", TBL[i].rq, i), t0, c0, p0, TBL[i].tk, TBL[i].cs, TBL[i].tg);
    end

    // R7: no supervisor, machine-delegated set goes straight to user.
    drive(16'h0100, 16'hFFFF, 16'h0100, 16'h0000, 1'b0, 1'b0, 1'b1, 2'b00);
    chk("R7 direct to user", t1, c1, p1, 1'b1, 4'd8, 2'b00);
    drive(16'h0100, 16'hFFFF, 16'h0100, 16'h0000, 1'b0, 1'b0, 1'b0, 2'b00);
    chk("R7 u_gie clear", t1, c1, p1, 1'b0, 4'd0, 2'b00);
    drive(16'h0100, 16'hFFFF, 16'h0100, 16'hFFFF, 1'b0, 1'b1, 1'b1, 2'b00);
    chk("R7 s_deleg ignored", t1, c1, p1, 1'b1, 4'd8, 2'b00);
    drive(16'h0100, 16'hFFFF, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 2'b00);
    chk("R7 undelegated at machine", t1, c1, p1, 1'b1, 4'd8, 2'b11);

    // R8: flat build ignores masks, enables and privilege.
    drive(16'h0222, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0, 2'b11);
    chk("R8 flat masks ignored", t2, c2, p2, 1'b1, 4'd9, 2'b11);
    drive(16'h0011, 16'h0010, 16'hFFFF, 16'hFFFF, 1'b0, 1'b1, 1'b1, 2'b00);
    chk("R8 flat enable only", t2, c2, p2, 1'b1, 4'd4, 2'b11);
    drive(16'h0BBB, 16'h0000, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b1, 2'b11);
    chk("R8 flat none enabled", t2, c2, p2, 1'b0, 4'd0, 2'b00);

    // R6: machine privilege with m_gie clear blocks all levels in u0.
    drive(16'h0BBB, 16'hFFFF, 16'h0222, 16'h0000, 1'b0, 1'b1, 1'b1, 2'b11);
    chk("R6 machine masked", t0, c0, p0, 1'b0, 4'd0, 2'b00);
    // R9: nonstandard bit beside a standard one; the standard one wins.
    drive(16'h7010, 16'hFFFF, 16'h0000, 16'h0000, 1'b1, 1'b0, 1'b0, 2'b11);
    chk("R9 standard bit picked", t0, c0, p0, 1'b1, 4'd4, 2'b11);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule